// File: doc/BRIEF.md
# Load-Use Stall Detector

This block finds the one pipeline hazard that forwarding cannot cover. The instruction in the ID/EX stage is a memory load, and the instruction now being decoded reads the register that the load will fill. The loaded value exists only after the memory stage, so the dependent instruction must wait one cycle.

When the condition holds, the block raises three separate stall controls:

- It drops the IF/ID write enable, so the decoded instruction stays in place.
- It raises a hold on the program counter, so fetch does not advance.
- It switches the ID/EX control-bit multiplexer to load a no-operation.

The block has no state. On the next clock the load moves out of ID/EX and the bubble takes its place. The bubble carries no memory-read flag, so the condition clears by itself and exactly one bubble is inserted.

Register 0 is treated as a constant register. A load that names it as destination never causes a stall.

Top module: `load_use_stall`

## Requirements
- R1: When there is no hazard, ifid_we_o is 1, pc_hold_o is 0 and bubble_o is 0.
- R2: When ex_mem_rd_i is 1 and ex_dst_i is nonzero and equal to id_src_a_i, then ifid_we_o is 0, pc_hold_o is 1 and bubble_o is 1.
- R3: When ex_mem_rd_i is 1 and ex_dst_i is nonzero and equal to id_src_b_i, the same three stall values appear as in R2.
- R4: When both sources equal a nonzero load destination, the outputs are the same single stall as in R2; there is no separate or stronger response.
- R5: When ex_mem_rd_i is 0, no stall is raised, whatever the addresses are.
- R6: When ex_dst_i is 0, no stall is raised, even for a load whose source addresses are 0.
- R7: At all times ifid_we_o equals the inverse of pc_hold_o, and bubble_o equals pc_hold_o.
- R8: The outputs depend on the inputs alone, with no register on the path. They change in the same cycle as the inputs. Once the bubble enters ID/EX (ex_mem_rd_i becomes 0), the stall clears, so only one bubble is inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_mem_rd_i | input | 1 | ID/EX instruction reads memory (load) |
| ex_dst_i | input | 5 | ID/EX destination register address |
| id_src_a_i | input | 5 | First source register address in ID |
| id_src_b_i | input | 5 | Second source register address in ID |
| ifid_we_o | output | 1 | IF/ID register write enable (0 = freeze) |
| pc_hold_o | output | 1 | Inhibit program counter increment |
| bubble_o | output | 1 | Select no-operation control bits into ID/EX |

## Verification
The bench drives a load with a match on the first source only, then on the second source only, then on both, then on neither. Comparing these cases shows whether each comparator reaches the stall on its own and whether the two are merged with OR.

The same address patterns are repeated with the memory-read flag low. This shows that a match alone never stalls.

A sweep over every destination address, with both sources equal to it, separates the register-0 exemption from ordinary matches.

A load-then-bubble sequence shows that the stall lasts exactly one cycle once the bubble reaches ID/EX.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned NSRC   = 2;

  typedef struct packed {
    logic ifid_we;
    logic pc_hold;
    logic bubble;
  } stall_ctrl_t;

  localparam stall_ctrl_t RUN_CTRL   = '{ifid_we: 1'b1, pc_hold: 1'b0, bubble: 1'b0};
  localparam stall_ctrl_t STALL_CTRL = '{ifid_we: 1'b0, pc_hold: 1'b1, bubble: 1'b1};
endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
  parameter int unsigned AW         = lu_pkg::REG_AW,
  parameter bit          ZERO_FIXED = 1'b1
) (
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] src_i,
  output logic          hit_o
);
  logic dst_live;

  generate
    if (ZERO_FIXED) begin : g_zero_fixed
      assign dst_live = |dst_i;
    end else begin : g_zero_plain
      assign dst_live = 1'b1;
    end
  endgenerate

  assign hit_o = dst_live && (dst_i == src_i);
endmodule

// File: rtl/lu_stall_drv.sv
module lu_stall_drv (
  input  logic                hazard_i,
  output lu_pkg::stall_ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = lu_pkg::RUN_CTRL;
    if (hazard_i) ctrl_o = lu_pkg::STALL_CTRL;
  end
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int unsigned AW         = lu_pkg::REG_AW,
  parameter bit          ZERO_FIXED = 1'b1
) (
  input  logic          ex_mem_rd_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic [AW-1:0] id_src_a_i,
  input  logic [AW-1:0] id_src_b_i,
  output logic          ifid_we_o,
  output logic          pc_hold_o,
  output logic          bubble_o
);
  localparam int unsigned NSRC = lu_pkg::NSRC;

  logic [AW-1:0]   src_vec [NSRC];
  logic [NSRC-1:0] src_hit;
  logic            hazard;
  lu_pkg::stall_ctrl_t ctrl;

  assign src_vec[0] = id_src_a_i;
  assign src_vec[1] = id_src_b_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    lu_src_cmp #(.AW(AW), .ZERO_FIXED(ZERO_FIXED)) u_cmp (
      .dst_i (ex_dst_i),
      .src_i (src_vec[i]),
      .hit_o (src_hit[i])
    );
  end

  // only a load can cause a stall; a match on any source is enough
  assign hazard = ex_mem_rd_i && (|src_hit);

  lu_stall_drv u_drv (
    .hazard_i (hazard),
    .ctrl_o   (ctrl)
  );

  assign ifid_we_o = ctrl.ifid_we;
  assign pc_hold_o = ctrl.pc_hold;
  assign bubble_o  = ctrl.bubble;
endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int unsigned AW = 5
) (
  input logic          ex_mem_rd_i,
  input logic [AW-1:0] ex_dst_i,
  input logic [AW-1:0] id_src_a_i,
  input logic [AW-1:0] id_src_b_i,
  input logic          ifid_we_o,
  input logic          pc_hold_o,
  input logic          bubble_o
);
  logic known;
  assign known = !$isunknown({ex_mem_rd_i, ex_dst_i, id_src_a_i, id_src_b_i,
                              ifid_we_o, pc_hold_o, bubble_o});

  always_comb begin
    if (known) begin
      assert_run_no_hit_R1: assert (ex_mem_rd_i && ex_dst_i != '0 &&
                                    (ex_dst_i == id_src_a_i || ex_dst_i == id_src_b_i)
                                    || ifid_we_o);
      assert_stall_src_a_R2: assert (!(ex_mem_rd_i && ex_dst_i != '0 &&
                                       ex_dst_i == id_src_a_i) || pc_hold_o);
      assert_stall_src_b_R3: assert (!(ex_mem_rd_i && ex_dst_i != '0 &&
                                       ex_dst_i == id_src_b_i) || bubble_o);
      assert_no_load_quiet_R5: assert (ex_mem_rd_i || !bubble_o);
      assert_zero_dst_quiet_R6: assert (ex_dst_i != '0 || !pc_hold_o);
      assert_ctrl_agree_R7: assert ((ifid_we_o == !pc_hold_o) && (bubble_o == pc_hold_o));
    end
  end
endmodule

bind load_use_stall load_use_stall_chk #(.AW(AW)) u_chk (
  .ex_mem_rd_i (ex_mem_rd_i),
  .ex_dst_i    (ex_dst_i),
  .id_src_a_i  (id_src_a_i),
  .id_src_b_i  (id_src_b_i),
  .ifid_we_o   (ifid_we_o),
  .pc_hold_o   (pc_hold_o),
  .bubble_o    (bubble_o)
);

// File: tb/load_use_stall_bench.sv
module load_use_stall_bench;
  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ex_mem_rd_i = 1'b0;
  logic [AW-1:0] ex_dst_i = '0;
  logic [AW-1:0] id_src_a_i = '0;
  logic [AW-1:0] id_src_b_i = '0;
  logic          ifid_we_o, pc_hold_o, bubble_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  load_use_stall u_load_use_stall (
    .ex_mem_rd_i (ex_mem_rd_i),
    .ex_dst_i    (ex_dst_i),
    .id_src_a_i  (id_src_a_i),
    .id_src_b_i  (id_src_b_i),
    .ifid_we_o   (ifid_we_o),
    .pc_hold_o   (pc_hold_o),
    .bubble_o    (bubble_o)
  );

  task automatic expect_out(input bit stall, input string req);
    logic [2:0] got, exp;
    got = {ifid_we_o, pc_hold_o, bubble_o};
    exp = stall ? 3'b011 : 3'b100;
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {we,hold,bubble} actual=%b expected=%b (rd=%0b dst=%0d a=%0d b=%0d)",
               req, got, exp, ex_mem_rd_i, ex_dst_i, id_src_a_i, id_src_b_i);
    end
  endtask

  task automatic drive(input bit rd, input int dst, input int a, input int b);
    @(negedge clk_i);
    ex_mem_rd_i = rd;
    ex_dst_i    = AW'(dst);
    id_src_a_i  = AW'(a);
    id_src_b_i  = AW'(b);
    #5;
  endtask

  task automatic t_reset_state;
    expect_out(1'b0, "R1 reset");
  endtask

  task automatic t_load_src_a;   // R2
    drive(1, 7, 7, 3);   expect_out(1'b1, "R2 load hits src a");
    drive(1, 31, 31, 0); expect_out(1'b1, "R2 load hits src a max addr");
  endtask

  task automatic t_load_src_b;   // R3
    drive(1, 9, 4, 9);   expect_out(1'b1, "R3 load hits src b");
    drive(1, 1, 0, 1);   expect_out(1'b1, "R3 load hits src b addr 1");
  endtask

  task automatic t_load_both;    // R4
    drive(1, 12, 12, 12); expect_out(1'b1, "R4 load hits both sources");
  endtask

  task automatic t_load_neither; // R1
    drive(1, 5, 6, 4);   expect_out(1'b0, "R1 load with no match");
    drive(0, 0, 0, 0);   expect_out(1'b0, "R1 idle");
  endtask

  task automatic t_no_load;      // R5
    drive(0, 7, 7, 3);   expect_out(1'b0, "R5 non-load match src a");
    drive(0, 9, 4, 9);   expect_out(1'b0, "R5 non-load match src b");
    drive(0, 12, 12, 12); expect_out(1'b0, "R5 non-load match both");
  endtask

  task automatic t_zero_sweep;   // R6, plus R2 for every nonzero address
    for (int d = 0; d < (1 << AW); d++) begin
      drive(1, d, d, d);
      expect_out(d != 0, d == 0 ? "R6 zero destination" : "R2 sweep match");
    end
    drive(1, 0, 0, 5); expect_out(1'b0, "R6 zero dst src a zero");
  endtask

  task automatic t_one_bubble;   // R8
    drive(1, 8, 2, 8);
    expect_out(1'b1, "R8 stall on load");
    // same cycle response: change inputs mid-cycle, no clock edge
    id_src_b_i = 5'd3;
    #1;
    expect_out(1'b0, "R8 combinational release");
    id_src_b_i = 5'd8;
    #1;
    expect_out(1'b1, "R8 combinational raise");
    // next cycle the bubble sits in ID/EX, the dependent instruction is still held in ID
    drive(0, 0, 2, 8);
    expect_out(1'b0, "R8 single bubble");
  endtask

  task automatic t_consistency;  // R7
    for (int k = 0; k < 40; k++) begin
      drive(k[0], (k * 7) % 32, (k * 3) % 32, (k * 5) % 32);
      n_cmp++;
      if (!(ifid_we_o === !pc_hold_o && bubble_o === pc_hold_o)) begin
        n_bad++;
        $display("FAIL R7: we=%b hold=%b bubble=%b expected we=~hold, bubble=hold",
                 ifid_we_o, pc_hold_o, bubble_o);
      end
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    #15;
    t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_load_src_a();
    t_load_src_b();
    t_load_both();
    t_load_neither();
    t_no_load();
    t_zero_sweep();
    t_one_bubble();
    t_consistency();
    done = 1'b1;
    finish_run();
  end
endmodule